// File: doc/BRIEF.md
# Buffered Mesh Router Output Port

This block is one outgoing direction of a two-dimensional mesh router. Three input sources may ask for the port in the same cycle. A fixed-priority selector picks one of them. A three-entry queue holds the accepted packets that cannot leave at once, either because the neighbour downstream reports that it is occupied or because earlier packets are still waiting.

A link controller drives the outgoing link. It never offers a packet while the neighbour is occupied. It keeps the head packet steady until that packet leaves. When the queue is empty and the link is free, the selected packet goes straight to the link in the same cycle without being stored.

For every accepted packet, the port sends a one-cycle release pulse back to the source that supplied it. It also raises a full flag so that the upstream routers stop offering packets.

Top module: `mesh_outport`

## Requirements
- R1: After reset, `link_valid_o`, `full_o` and every bit of `release_o` are low.
- R2: Among requesting sources, source 0 wins over source 1 and source 1 wins over source 2. Source i uses bits [i*DATA_W +: DATA_W] of `src_data_i` and bit i of `src_req_i`. Only the winner can be accepted in a cycle, and a losing source gets no release.
- R3: In the cycle a packet is accepted, `release_o` carries exactly one high bit, at the winner's index. In every other cycle it is all zero.
- R4: If the queue is empty and `link_occ_i` is low, the winning packet appears on `link_data_o` with `link_valid_o` high in the same cycle.
- R5: While `link_occ_i` is high, `link_valid_o` stays low. Requests are still accepted into the queue while space remains.
- R6: `full_o` is high exactly when three packets are stored. A request made while full and occupied is not accepted, and no release is given.
- R7: Stored packets leave in acceptance order, one per cycle in which `link_occ_i` is low.
- R8: When the queue is full and `link_occ_i` is low, a request is accepted in the same cycle that the head packet leaves.
- R9: When the queue is not empty, a newly accepted packet is placed behind the stored ones and does not bypass them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | 3 | Per-source request for this direction |
| src_data_i | input | 48 | Packet words of the three sources, packed by index |
| release_o | output | 3 | One-cycle release pulse to the source that was accepted |
| full_o | output | 1 | High while the queue holds three packets |
| link_occ_i | input | 1 | Downstream neighbour occupied |
| link_valid_o | output | 1 | Packet offered on the link; it is taken in the same cycle |
| link_data_o | output | 16 | Packet word on the link |

## Verification
The hardest case to reach is the full queue meeting a new request. Getting there takes three accepted packets while the link is occupied. After that, the next request must arrive in two ways: once with the neighbour still occupied, where it must be refused, and once on the first free cycle, where it must be accepted and the head must leave together. The stimulus holds occupancy high while it feeds the three sources one after another, then probes both variants. A scoreboard follows the order in which packets leave, and occupancy is toggled cycle by cycle to show that the head is held.

// File: rtl/outport_pkg.sv
package outport_pkg;
  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_SEND     = 2'd1,
    PH_WAIT_OCC = 2'd2
  } link_phase_e;
endpackage

// File: rtl/outport_xbar.sv
module outport_xbar #(
  parameter int NSRC   = 3,
  parameter int DATA_W = 16
) (
  input  logic [NSRC-1:0]        req_i,
  input  logic [NSRC*DATA_W-1:0] data_i,
  output logic [NSRC-1:0]        grant_o,
  output logic                   any_o,
  output logic [DATA_W-1:0]      win_data_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_prio
    if (g == 0) begin : g_top
      assign grant_o[g] = req_i[g];
    end else begin : g_low
      assign grant_o[g] = req_i[g] & ~(|req_i[g-1:0]);
    end
  end

  assign any_o = |req_i;

  always_comb begin
    win_data_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      win_data_o = win_data_o | (data_i[i*DATA_W +: DATA_W] & {DATA_W{grant_o[i]}});
    end
  end
endmodule

// File: rtl/outport_fifo.sv
module outport_fifo #(
  parameter int DEPTH  = 3,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push_i,
  input  logic                          pop_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             head_o,
  output logic [$clog2(DEPTH+1)-1:0]    cnt_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push_i) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (pop_i)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    if (push_i && !pop_i) cnt_d = cnt_q + 1'b1;
    else if (!push_i && pop_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  assign head_o = mem_q[rp_q];
  assign cnt_o  = cnt_q;

  // R6: never write into a full queue unless the head leaves in the same cycle
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && cnt_q == CW'(DEPTH)) |-> pop_i);
  // R7: the head entry is held while it is not removed
  p_head_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !pop_i) |=> $stable(head_o));
endmodule

// File: rtl/outport_ctrl.sv
module outport_ctrl
  import outport_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic                       occ_i,
  input  logic                       win_any_i,
  input  logic [$clog2(DEPTH+1)-1:0] cnt_i,
  output link_phase_e                phase_o,
  output logic                       accept_o,
  output logic                       push_o,
  output logic                       pop_o,
  output logic                       bypass_o,
  output logic                       full_o
);
  localparam int CW = $clog2(DEPTH + 1);
  logic q_empty, pending;

  assign q_empty  = (cnt_i == '0);
  assign full_o   = (cnt_i == CW'(DEPTH));
  assign pop_o    = ~q_empty & ~occ_i;
  assign bypass_o = q_empty & ~occ_i & win_any_i;
  assign accept_o = win_any_i & (~full_o | pop_o);
  assign push_o   = accept_o & ~bypass_o;
  assign pending  = ~q_empty | win_any_i;

  always_comb begin
    if (!pending)   phase_o = PH_IDLE;
    else if (occ_i) phase_o = PH_WAIT_OCC;
    else            phase_o = PH_SEND;
  end
endmodule

// File: rtl/mesh_outport.sv
module mesh_outport
  import outport_pkg::*;
#(
  parameter int NSRC   = 3,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        src_req_i,
  input  logic [NSRC*DATA_W-1:0] src_data_i,
  output logic [NSRC-1:0]        release_o,
  output logic                   full_o,
  input  logic                   link_occ_i,
  output logic                   link_valid_o,
  output logic [DATA_W-1:0]      link_data_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [NSRC-1:0]   grant;
  logic              win_any, accept, push, pop, bypass;
  logic [DATA_W-1:0] win_data, head;
  logic [CW-1:0]     cnt;
  link_phase_e       phase;

  outport_xbar #(.NSRC(NSRC), .DATA_W(DATA_W)) u_xbar (
    .req_i(src_req_i), .data_i(src_data_i), .grant_o(grant),
    .any_o(win_any), .win_data_o(win_data));

  outport_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .occ_i(link_occ_i), .win_any_i(win_any), .cnt_i(cnt), .phase_o(phase),
    .accept_o(accept), .push_o(push), .pop_o(pop), .bypass_o(bypass),
    .full_o(full_o));

  outport_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
    .wdata_i(win_data), .head_o(head), .cnt_o(cnt));

  assign release_o    = grant & {NSRC{accept}};
  assign link_valid_o = (phase == PH_SEND);
  assign link_data_o  = bypass ? win_data : head;

  // R5: no link offer while the neighbour is occupied
  p_no_offer_occ_r5: assert property (@(posedge clk) disable iff (!rst_n)
    link_occ_i |-> !link_valid_o);
  // R3: at most one release per cycle
  p_release_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(release_o));
  // R6: full and occupied means nothing is accepted
  p_full_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && link_occ_i) |-> (release_o == '0));
  // R2: a released source has no higher-priority rival requesting
  for (genvar g = 1; g < NSRC; g++) begin : g_prio_chk
    p_priority_r2: assert property (@(posedge clk) disable iff (!rst_n)
      release_o[g] |-> (src_req_i[g-1:0] == '0));
  end
endmodule

// File: tb/mesh_outport_test.sv
module mesh_outport_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  src_req_i;
  logic [47:0] src_data_i;
  logic [2:0]  release_o;
  logic        full_o;
  logic        link_occ_i;
  logic        link_valid_o;
  logic [15:0] link_data_o;

  int vectors = 0;
  int errors  = 0;
  int mcount  = 0;
  logic [15:0] expq [$];
  bit done = 0;

  always #2 clk = ~clk;

  mesh_outport uut (
    .clk(clk), .rst_n(rst_n), .src_req_i(src_req_i), .src_data_i(src_data_i),
    .release_o(release_o), .full_o(full_o), .link_occ_i(link_occ_i),
    .link_valid_o(link_valid_o), .link_data_o(link_data_o));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Scoreboard monitor: each packet on the link must match the oldest expected one
  always @(negedge clk) begin
    if (rst_n && link_valid_o) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R7", "unexpected link packet", link_data_o, 16'h0);
      end else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(link_data_o == e, "R7", "link order/data", link_data_o, e);
      end
    end
  end

  task automatic step(input logic [2:0] rq, input logic [15:0] a, b, c,
                      input logic occ, input string tag);
    logic [2:0] g;
    logic [15:0] wd;
    bit acc, byp, deq, enq, vexp, fexp;
    @(posedge clk); #1;
    src_req_i  = rq;
    src_data_i = {c, b, a};
    link_occ_i = occ;
    g  = rq[0] ? 3'b001 : rq[1] ? 3'b010 : rq[2] ? 3'b100 : 3'b000;
    wd = rq[0] ? a : rq[1] ? b : c;
    deq  = (mcount > 0) && !occ;
    byp  = (mcount == 0) && !occ && (rq != 0);
    acc  = (rq != 0) && ((mcount < 3) || deq);
    enq  = acc && !byp;
    vexp = !occ && ((mcount > 0) || byp);
    fexp = (mcount == 3);
    if (acc) expq.push_back(wd);
    #2;
    chk(release_o == (acc ? g : 3'b000), tag, "release", {13'h0, release_o},
        {13'h0, (acc ? g : 3'b000)});
    chk(link_valid_o == vexp, tag, "link_valid", {15'h0, link_valid_o}, {15'h0, vexp});
    chk(full_o == fexp, tag, "full", {15'h0, full_o}, {15'h0, fexp});
    mcount = mcount + int'(enq) - int'(deq);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    src_req_i = '0;
    src_data_i = '0;
    link_occ_i = 1'b0;
    #11;
    chk(link_valid_o == 1'b0, "R1", "reset valid", {15'h0, link_valid_o}, 16'h0);
    chk(full_o == 1'b0, "R1", "reset full", {15'h0, full_o}, 16'h0);
    chk(release_o == 3'b000, "R1", "reset release", {13'h0, release_o}, 16'h0);
    @(negedge clk); rst_n = 1'b1;

    // R4 bypass, single source; R3 release to that source
    step(3'b010, 16'h1111, 16'hA001, 16'h3333, 1'b0, "R4");
    step(3'b000, 16'h0, 16'h0, 16'h0, 1'b0, "R3");
    // R2 priority under contention
    step(3'b111, 16'hA100, 16'hA101, 16'hA102, 1'b0, "R2");
    step(3'b110, 16'hA200, 16'hA201, 16'hA202, 1'b0, "R2");
    step(3'b100, 16'hA300, 16'hA301, 16'hA302, 1'b0, "R2");
    step(3'b101, 16'hA400, 16'hA401, 16'hA402, 1'b0, "R2");
    // R5 store while occupied, link silent
    step(3'b001, 16'hB001, 16'h0, 16'h0, 1'b1, "R5");
    step(3'b110, 16'h0, 16'hB002, 16'hB0FF, 1'b1, "R5");
    step(3'b100, 16'h0, 16'h0, 16'hB003, 1'b1, "R5");
    // R6 full and occupied: refused
    step(3'b001, 16'hBEEF, 16'h0, 16'h0, 1'b1, "R6");
    step(3'b000, 16'h0, 16'h0, 16'h0, 1'b1, "R6");
    // R8 full, link free: accept and send together
    step(3'b010, 16'h0, 16'hB004, 16'h0, 1'b0, "R8");
    // R7 drain in order
    for (int i = 0; i < 4; i++) step(3'b000, 16'h0, 16'h0, 16'h0, 1'b0, "R7");
    // R9 no bypass of stored packets
    step(3'b001, 16'hC001, 16'h0, 16'h0, 1'b1, "R9");
    step(3'b100, 16'h0, 16'h0, 16'hC002, 1'b0, "R9");
    step(3'b010, 16'h0, 16'hC003, 16'h0, 1'b0, "R9");
    step(3'b000, 16'h0, 16'h0, 16'h0, 1'b0, "R9");
    // R7 head held across occupancy toggles
    step(3'b001, 16'hD001, 16'h0, 16'h0, 1'b1, "R7");
    step(3'b001, 16'hD002, 16'h0, 16'h0, 1'b1, "R7");
    step(3'b000, 16'h0, 16'h0, 16'h0, 1'b0, "R7");
    step(3'b000, 16'h0, 16'h0, 16'h0, 1'b1, "R7");
    step(3'b000, 16'h0, 16'h0, 16'h0, 1'b0, "R7");
    step(3'b000, 16'h0, 16'h0, 16'h0, 1'b0, "R3");
    @(posedge clk); #3;
    chk(expq.size() == 0, "R7", "scoreboard drained", 16'(expq.size()), 16'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule